// File: doc/BRIEF.md
# Converter sample queue with sweep playback

This block sits in front of a converter's output register. It holds the digital sample that the converter shows on `dac_out` and decides when that sample changes. Software programs it through a small word-addressed register port. The port carries one write strobe, an address and write data, and returns read data combinationally.

The block has three playback modes. In direct mode a data write goes straight to the output and the queue is bypassed. In queue mode each trigger moves the oldest stored sample to the output. In sweep mode the stored samples are retained. Successive triggers walk the read index from entry zero up to the newest entry, then back down to zero, and this repeats. That makes it suited to triangle-like or back-and-forth waveforms.

A trigger comes either from a hardware input or from a software strobe. The hardware input is synchronised and edge-detected. The block reports six conditions: full, empty, low-level, sweep-period done, lost write and starved trigger. Each condition can raise an interrupt, and two of them can request DMA. A queue-only clear and a whole-block clear are both level controls that stay in effect until software removes them.

Top module: `dac_sample_fifo`

## Requirements
- R1: After reset, `dac_out` is 0, `irq` and `dma_req` are 0, the index register (address 7) reads 0, and the status register (address 4) reads 0x06. Status bit positions are: bit 0 full, bit 1 empty, bit 2 low-level, bit 3 sweep-done, bit 4 lost-write, bit 5 starved-trigger.
- R2: The control register (address 0) holds: bit 0 enable, bits 2:1 mode, bit 3 trigger source, bits 12:8 low-level threshold. Mode 0 (and the unused code 3) is direct mode. In direct mode a write to address 5 appears on `dac_out` at the next clock edge. Triggers in direct mode change neither the output nor the indices.
- R3: In queue mode (mode 1), each trigger puts the oldest stored sample on `dac_out` and advances the read index by one. Samples come out in write order. The index register shows the read index in bits 3:0 and the write index in bits 7:4.
- R4: In sweep mode (mode 2), each trigger outputs the entry at the read index, then steps the index. The index steps up until it reaches the newest entry (write index minus one), then steps down to zero, and this repeats. With three entries written, the index visits 0,1,2,1,0,1 and the stored data are kept.
- R5: In sweep mode, status bit 3 sets on the trigger that returns the read index to zero after it has reached the top. With three entries this is the fourth trigger. The bit stays set until it is cleared.
- R6: While sweep mode is selected, the full, empty and low-level bits keep their values even when samples are written. They follow the sample count again once another mode is selected.
- R7: A trigger in queue or sweep mode with no stored samples sets status bit 5. The read index and `dac_out` are left unchanged.
- R8: A data write in queue or sweep mode with 16 samples stored sets status bit 4. The write index is not advanced and the sample is discarded.
- R9: Outside sweep mode, status bit 2 equals (stored count <= threshold), so it clears by itself once the count exceeds the threshold.
- R10: Writing 1 to status bits 3, 4 or 5 clears them. Writes to status bits 0 to 2 have no effect.
- R11: With control bit 3 at 0, a rising edge on `hw_trig` gives exactly one trigger, however long the pulse. With control bit 3 at 1, writing 1 to bit 0 of address 6 gives one trigger. The unselected source is ignored, and all triggers are ignored while control bit 0 is 0.
- R12: Bit 0 of address 1 is the queue clear. While it is set, the indices, the count and the status are held at their reset values, data writes to the queue are ignored, and the control settings are kept. Bit 1 of address 1 is the block clear. While it is set, the control, interrupt-enable and DMA-enable registers, the queue and `dac_out` are all held at 0.
- R13: `irq` is the OR of the status bits ANDed with the interrupt-enable register (address 2, same bit order as status). `dma_req` is (DMA-enable bit 0 AND empty) OR (DMA-enable bit 1 AND low-level), where DMA-enable is address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| hw_trig | input | 1 | Hardware trigger, asynchronous |
| dac_out | output | 12 | Sample presented to the converter |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
On every cycle, the assertions check four things. The sample count never exceeds the depth. A rejected write leaves the write index alone. A starved trigger leaves the output and the read index alone. A sweep period always ends with the read index at zero.

They also check that the level flags stay still across sweep-mode cycles and that a synchronised hardware edge lasts one cycle. Only the directed scenarios can show the actual sample order in queue and sweep mode, and which trigger completes a sweep period. The same holds for the threshold arithmetic, for which status bits are write-one-to-clear, and for what each clear control keeps and what it wipes.

// File: rtl/dsf_pkg.sv
package dsf_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_QUEUE  = 2'd1,
    MODE_SWEEP  = 2'd2,
    MODE_SPARE  = 2'd3
  } dsf_mode_e;

  // register word addresses
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CLR  = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_DEN  = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;
  localparam logic [2:0] A_TRIG = 3'd6;
  localparam logic [2:0] A_IDX  = 3'd7;

  // control field positions
  localparam int C_EN   = 0;
  localparam int C_MODE = 1;
  localparam int C_SRC  = 3;
  localparam int C_THR  = 8;

  // status bit positions
  localparam int NFLAG   = 6;
  localparam int F_FULL  = 0;
  localparam int F_EMPTY = 1;
  localparam int F_LOW   = 2;
  localparam int F_SWEEP = 3;
  localparam int F_LOST  = 4;
  localparam int F_STARV = 5;

  localparam logic [NFLAG-1:0] STICKY_MASK = 6'b111000;

endpackage

// File: rtl/dsf_regs.sv
module dsf_regs
  import dsf_pkg::*;
#(
  parameter int DW  = 12,
  parameter int PW  = 4,
  parameter int TW  = 5,
  parameter int BW  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wen,
  input  logic [2:0]       addr,
  input  logic [BW-1:0]    wdata,
  output logic [BW-1:0]    rdata,
  input  logic [NFLAG-1:0] flags,
  input  logic [PW-1:0]    rd_idx,
  input  logic [PW-1:0]    wr_idx,
  input  logic [DW-1:0]    sample,
  output logic             en,
  output dsf_mode_e        mode,
  output logic             src_sw,
  output logic [TW-1:0]    thr,
  output logic [NFLAG-1:0] ien,
  output logic [1:0]       den,
  output logic             q_clr,
  output logic             blk_clr,
  output logic             data_wr,
  output logic             sw_pulse,
  output logic [NFLAG-1:0] ack_mask
);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_clr   <= 1'b0;
      blk_clr <= 1'b0;
    end else if (wen && addr == A_CLR) begin
      q_clr   <= wdata[0];
      blk_clr <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      mode   <= MODE_DIRECT;
      src_sw <= 1'b0;
      thr    <= '0;
      ien    <= '0;
      den    <= '0;
    end else if (blk_clr) begin
      en     <= 1'b0;
      mode   <= MODE_DIRECT;
      src_sw <= 1'b0;
      thr    <= '0;
      ien    <= '0;
      den    <= '0;
    end else if (wen) begin
      case (addr)
        A_CTRL: begin
          en     <= wdata[C_EN];
          mode   <= dsf_mode_e'(wdata[C_MODE +: 2]);
          src_sw <= wdata[C_SRC];
          thr    <= wdata[C_THR +: TW];
        end
        A_IEN:   ien <= wdata[NFLAG-1:0];
        A_DEN:   den <= wdata[1:0];
        default: ;
      endcase
    end
  end

  assign data_wr  = wen && (addr == A_DATA) && !blk_clr;
  assign sw_pulse = wen && (addr == A_TRIG) && wdata[0];
  assign ack_mask = (wen && addr == A_STAT) ? (wdata[NFLAG-1:0] & STICKY_MASK) : '0;

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[C_EN]         = en;
        rdata[C_MODE +: 2]  = mode;
        rdata[C_SRC]        = src_sw;
        rdata[C_THR +: TW]  = thr;
      end
      A_CLR:  rdata[1:0]       = {blk_clr, q_clr};
      A_IEN:  rdata[NFLAG-1:0] = ien;
      A_DEN:  rdata[1:0]       = den;
      A_STAT: rdata[NFLAG-1:0] = flags;
      A_DATA: rdata[DW-1:0]    = sample;
      A_IDX: begin
        rdata[PW-1:0]    = rd_idx;
        rdata[PW +: PW]  = wr_idx;
      end
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/dsf_trig.sv
module dsf_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic blk_clr,
  input  logic hw_trig,
  input  logic sw_pulse,
  input  logic src_sw,
  input  logic en,
  output logic trig_evt
);

  logic s1, s2, s_prev;
  logic hw_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s_prev <= 1'b0;
    end else begin
      s1     <= hw_trig;
      s2     <= s1;
      s_prev <= s2;
    end
  end

  assign hw_rise  = s2 & ~s_prev;
  assign trig_evt = en & ~blk_clr & (src_sw ? sw_pulse : hw_rise);

  AST_ONE_STEP_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rise |=> !hw_rise); // R11

endmodule

// File: rtl/dsf_store.sv
module dsf_store
  import dsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_clr,
  input  logic             q_clr,
  input  dsf_mode_e        mode,
  input  logic [CW-1:0]    thr,
  input  logic             push,
  input  logic [DW-1:0]    push_data,
  input  logic             trig,
  input  logic [NFLAG-1:0] ack_mask,
  output logic [DW-1:0]    dac_out,
  output logic [NFLAG-1:0] flags,
  output logic [PW-1:0]    rd_idx,
  output logic [PW-1:0]    wr_idx
);

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // next sweep step: {next_up, period_done, next_index}
  function automatic logic [PW+1:0] sweep_step(input logic [PW-1:0] cur,
                                               input logic [PW-1:0] top,
                                               input logic up);
    logic [PW-1:0] nxt;
    logic          dn;
    logic          nup;
    if (top == '0) begin
      nxt = '0; dn = 1'b1; nup = 1'b1;
    end else if (up && cur != top) begin
      nxt = cur + 1'b1; dn = 1'b0; nup = 1'b1;
    end else begin
      nxt = cur - 1'b1; dn = (nxt == '0); nup = dn;
    end
    return {nup, dn, nxt};
  endfunction

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] c,
                                               input logic inc, input logic dec);
    return c + CW'(inc) - CW'(dec);
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt, cnt_d;
  logic          dir_up;
  logic          full_q, empty_q, low_q, sweep_q, lost_q, starv_q;

  logic          queue_on, sweep_on, hold;
  logic          push_ok, lost_evt, trig_ok, starv_evt, pop_evt, sweep_evt, period_evt;
  logic [PW-1:0] top_idx;
  logic [PW+1:0] step;

  assign queue_on   = (mode == MODE_QUEUE) || (mode == MODE_SWEEP);
  assign sweep_on   = (mode == MODE_SWEEP);
  assign hold       = blk_clr | q_clr;
  assign push_ok    = push & queue_on & ~hold & (cnt != FULL_CNT);
  assign lost_evt   = push & queue_on & ~hold & (cnt == FULL_CNT);
  assign trig_ok    = trig & queue_on & ~hold;
  assign starv_evt  = trig_ok & (cnt == '0);
  assign pop_evt    = trig_ok & (cnt != '0) & ~sweep_on;
  assign sweep_evt  = trig_ok & (cnt != '0) & sweep_on;
  assign top_idx    = wr_idx - 1'b1;
  assign step       = sweep_step(rd_idx, top_idx, dir_up);
  assign period_evt = sweep_evt & step[PW];
  assign cnt_d      = next_count(cnt, push_ok, pop_evt);

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_idx] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; rd_idx <= '0; wr_idx <= '0; dir_up <= 1'b1;
      full_q <= 1'b0; empty_q <= 1'b1; low_q <= 1'b1;
      sweep_q <= 1'b0; lost_q <= 1'b0; starv_q <= 1'b0;
    end else if (hold) begin
      cnt <= '0; rd_idx <= '0; wr_idx <= '0; dir_up <= 1'b1;
      full_q <= 1'b0; empty_q <= 1'b1; low_q <= 1'b1;
      sweep_q <= 1'b0; lost_q <= 1'b0; starv_q <= 1'b0;
    end else begin
      cnt <= cnt_d;
      if (push_ok) wr_idx <= wr_idx + 1'b1;
      if (pop_evt) rd_idx <= rd_idx + 1'b1;
      if (sweep_evt) begin
        rd_idx <= step[PW-1:0];
        dir_up <= step[PW+1];
      end
      if (!sweep_on) begin
        full_q  <= (cnt_d == FULL_CNT);
        empty_q <= (cnt_d == '0);
        low_q   <= (cnt_d <= thr);
      end
      sweep_q <= (sweep_q & ~ack_mask[F_SWEEP]) | period_evt;
      lost_q  <= (lost_q  & ~ack_mask[F_LOST])  | lost_evt;
      starv_q <= (starv_q & ~ack_mask[F_STARV]) | starv_evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dac_out <= '0;
    else if (blk_clr) dac_out <= '0;
    else if (push && !queue_on) dac_out <= push_data;
    else if (pop_evt || sweep_evt) dac_out <= mem[rd_idx];
  end

  always_comb begin
    flags          = '0;
    flags[F_FULL]  = full_q;
    flags[F_EMPTY] = empty_q;
    flags[F_LOW]   = low_q;
    flags[F_SWEEP] = sweep_q;
    flags[F_LOST]  = lost_q;
    flags[F_STARV] = starv_q;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT); // R8
  AST_LOST_KEEPS_WIDX: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> $stable(wr_idx)); // R8
  AST_STARVED_KEEPS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    starv_evt |=> ($stable(dac_out) && $stable(rd_idx))); // R7
  AST_SWEEP_FLAGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_on && $past(sweep_on) && !$past(hold)) |-> $stable({full_q, empty_q, low_q})); // R6
  AST_PERIOD_ENDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    period_evt |=> (rd_idx == '0)); // R5

endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
  import dsf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 12,
  parameter int BW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [2:0]    reg_addr,
  input  logic [BW-1:0] reg_wdata,
  output logic [BW-1:0] reg_rdata,
  input  logic          hw_trig,
  output logic [DW-1:0] dac_out,
  output logic          irq,
  output logic          dma_req
);

  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  dsf_mode_e        mode;
  logic             en, src_sw, q_clr, blk_clr, data_wr, sw_pulse, trig_evt;
  logic [CW-1:0]    thr;
  logic [NFLAG-1:0] ien, ack_mask, flags;
  logic [1:0]       den;
  logic [PW-1:0]    rd_idx, wr_idx;

  dsf_regs #(.DW(DW), .PW(PW), .TW(CW), .BW(BW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .flags(flags), .rd_idx(rd_idx), .wr_idx(wr_idx),
    .sample(dac_out), .en(en), .mode(mode), .src_sw(src_sw), .thr(thr),
    .ien(ien), .den(den), .q_clr(q_clr), .blk_clr(blk_clr),
    .data_wr(data_wr), .sw_pulse(sw_pulse), .ack_mask(ack_mask)
  );

  dsf_trig u_trig (
    .clk(clk), .rst_n(rst_n), .blk_clr(blk_clr), .hw_trig(hw_trig),
    .sw_pulse(sw_pulse), .src_sw(src_sw), .en(en), .trig_evt(trig_evt)
  );

  dsf_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .blk_clr(blk_clr), .q_clr(q_clr), .mode(mode),
    .thr(thr), .push(data_wr), .push_data(reg_wdata[DW-1:0]), .trig(trig_evt),
    .ack_mask(ack_mask), .dac_out(dac_out), .flags(flags),
    .rd_idx(rd_idx), .wr_idx(wr_idx)
  );

  assign irq     = |(flags & ien);
  assign dma_req = (den[0] & flags[F_EMPTY]) | (den[1] & flags[F_LOW]);

endmodule

// File: tb/test_dac_sample_fifo.sv
module test_dac_sample_fifo;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        hw_trig = 1'b0;
  logic [11:0] dac_out;
  logic        irq, dma_req;

  int total = 0;
  int bad = 0;

  localparam logic [2:0] CTRL = 3'd0, CLR = 3'd1, IEN = 3'd2, DEN = 3'd3,
                         STAT = 3'd4, DATA = 3'd5, TRIG = 3'd6, IDX = 3'd7;
  // control words: bit0 enable, bits2:1 mode, bit3 software source
  localparam logic [15:0] DIRECT_SW = 16'h0009, QUEUE_SW = 16'h000B,
                          SWEEP_SW = 16'h000D, QUEUE_HW = 16'h0003;

  always #5 clk = ~clk;

  dac_sample_fifo i_dac_sample_fifo (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
    .dac_out(dac_out), .irq(irq), .dma_req(dma_req)
  );

  task automatic chk(input string what, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic chk_reg(input string what, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(what, v, exp);
  endtask

  task automatic soft_trig();
    wr(TRIG, 16'h0001);
  endtask

  task automatic queue_clear();
    wr(CLR, 16'h0001);
    wr(CLR, 16'h0000);
  endtask

  task automatic hw_pulse();
    @(negedge clk) hw_trig = 1'b1;
    repeat (5) @(negedge clk);
    hw_trig = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 dac_out", {4'h0, dac_out}, 16'h0000);
    chk("R1 irq/dma", {14'h0, irq, dma_req}, 16'h0000);
    chk_reg("R1 status", STAT, 16'h0006);
    chk_reg("R1 index", IDX, 16'h0000);
  endtask

  task automatic t_direct();
    wr(CTRL, DIRECT_SW);
    wr(DATA, 16'h0ABC);
    chk("R2 direct write", {4'h0, dac_out}, 16'h0ABC);
    soft_trig();
    chk("R2 trigger ignored out", {4'h0, dac_out}, 16'h0ABC);
    chk_reg("R2 trigger ignored idx", IDX, 16'h0000);
  endtask

  task automatic t_queue();
    wr(CTRL, QUEUE_SW);
    queue_clear();
    wr(DATA, 16'h0111); wr(DATA, 16'h0222); wr(DATA, 16'h0333);
    chk_reg("R3 index after writes", IDX, 16'h0030);
    chk_reg("R9 status three stored", STAT, 16'h0000);
    soft_trig();
    chk("R3 first pop", {4'h0, dac_out}, 16'h0111);
    soft_trig();
    chk("R3 second pop", {4'h0, dac_out}, 16'h0222);
    chk_reg("R3 index", IDX, 16'h0032);
    soft_trig();
    chk("R3 third pop", {4'h0, dac_out}, 16'h0333);
    chk_reg("R1 empty again", STAT, 16'h0006);
    soft_trig();
    chk_reg("R7 starved flag", STAT, 16'h0026);
    chk("R7 output kept", {4'h0, dac_out}, 16'h0333);
    chk_reg("R7 index kept", IDX, 16'h0033);
    wr(STAT, 16'h0027);
    chk_reg("R10 w1c clears only sticky", STAT, 16'h0006);
  endtask

  task automatic t_lost();
    wr(CTRL, QUEUE_SW);
    queue_clear();
    for (int i = 0; i < 16; i++) wr(DATA, 16'h0100 + 16'(i));
    chk_reg("R8 full", STAT, 16'h0001);
    wr(DATA, 16'h0FFF);
    chk_reg("R8 lost flag", STAT, 16'h0011);
    chk_reg("R8 write index kept", IDX, 16'h0000);
    for (int i = 0; i < 16; i++) soft_trig();
    chk("R8 extra word discarded", {4'h0, dac_out}, 16'h010F);
    chk_reg("R8 drained", STAT, 16'h0016);
    wr(STAT, 16'h0010);
    chk_reg("R10 lost cleared", STAT, 16'h0006);
  endtask

  task automatic t_low();
    wr(CTRL, 16'h020B);
    queue_clear();
    chk_reg("R9 empty below thr", STAT, 16'h0006);
    wr(DATA, 16'h0001);
    chk_reg("R9 count1", STAT, 16'h0004);
    wr(DATA, 16'h0002);
    chk_reg("R9 count2 equal", STAT, 16'h0004);
    wr(DATA, 16'h0003);
    chk_reg("R9 count3 above", STAT, 16'h0000);
    soft_trig();
    chk_reg("R9 back to two", STAT, 16'h0004);
  endtask

  task automatic t_sweep();
    wr(CTRL, SWEEP_SW);
    queue_clear();
    wr(DATA, 16'h0A00); wr(DATA, 16'h0A01); wr(DATA, 16'h0A02);
    chk_reg("R6 flags frozen", STAT, 16'h0006);
    soft_trig();
    chk("R4 t1", {4'h0, dac_out}, 16'h0A00);
    chk_reg("R4 t1 idx", IDX, 16'h0031);
    soft_trig();
    chk("R4 t2", {4'h0, dac_out}, 16'h0A01);
    soft_trig();
    chk("R4 t3", {4'h0, dac_out}, 16'h0A02);
    chk_reg("R5 not yet", STAT, 16'h0006);
    soft_trig();
    chk("R4 t4", {4'h0, dac_out}, 16'h0A01);
    chk_reg("R4 t4 idx", IDX, 16'h0030);
    chk_reg("R5 period done", STAT, 16'h000E);
    soft_trig();
    chk("R4 t5 data kept", {4'h0, dac_out}, 16'h0A00);
    wr(CTRL, QUEUE_SW);
    chk_reg("R6 flags follow again", STAT, 16'h0008);
    wr(STAT, 16'h0008);
    chk_reg("R5 sticky cleared", STAT, 16'h0000);
  endtask

  task automatic t_hw();
    wr(CTRL, QUEUE_HW);
    queue_clear();
    wr(DATA, 16'h0B00); wr(DATA, 16'h0B01);
    hw_pulse();
    chk("R11 one pop per pulse", {4'h0, dac_out}, 16'h0B00);
    chk_reg("R11 one step", IDX, 16'h0021);
    soft_trig();
    chk_reg("R11 sw ignored", IDX, 16'h0021);
    wr(CTRL, 16'h0002);
    hw_pulse();
    chk_reg("R11 disabled ignores", IDX, 16'h0021);
    wr(CTRL, QUEUE_HW);
    hw_pulse();
    chk("R11 second pulse", {4'h0, dac_out}, 16'h0B01);
  endtask

  task automatic t_irq();
    wr(CTRL, QUEUE_SW);
    queue_clear();
    wr(IEN, 16'h0002);
    chk("R13 irq empty", {15'h0, irq}, 16'h0001);
    wr(IEN, 16'h0001);
    chk("R13 irq masked", {15'h0, irq}, 16'h0000);
    soft_trig();
    wr(IEN, 16'h0020);
    chk("R13 irq starved", {15'h0, irq}, 16'h0001);
    wr(DEN, 16'h0002);
    chk("R13 dma low", {15'h0, dma_req}, 16'h0001);
    wr(DEN, 16'h0001);
    chk("R13 dma empty", {15'h0, dma_req}, 16'h0001);
    wr(DATA, 16'h0055);
    chk("R13 dma drops", {15'h0, dma_req}, 16'h0000);
    wr(IEN, 16'h0000); wr(DEN, 16'h0000);
  endtask

  task automatic t_clears();
    wr(CTRL, 16'h020B);
    wr(CLR, 16'h0001);
    wr(DATA, 16'h0077);
    chk_reg("R12 queue clear keeps ctrl", CTRL, 16'h020B);
    chk_reg("R12 writes ignored while held", IDX, 16'h0000);
    wr(CLR, 16'h0000);
    chk_reg("R12 status after queue clear", STAT, 16'h0006);
    wr(IEN, 16'h003F);
    wr(CLR, 16'h0002);
    chk_reg("R12 block clear ctrl", CTRL, 16'h0000);
    wr(CLR, 16'h0000);
    chk_reg("R12 ien cleared", IEN, 16'h0000);
    chk("R12 output cleared", {4'h0, dac_out}, 16'h0000);
    chk_reg("R12 status", STAT, 16'h0006);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_queue();
    t_lost();
    t_low();
    t_sweep();
    t_hw();
    t_irq();
    t_clears();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule